// File: doc/BRIEF.md
# Flit-Drop Word-Repeat Packet Composer

This block sits in a network interface and turns one cache block (sixteen 32-bit words) plus a 16-bit used-vector into a wormhole packet of 131-bit flits. A packet opens with a head flit carrying the addressing information. It is followed by up to four data flits of four words each. A data flit whose four words are all marked unused is left out of the packet. Inside a flit that is sent, every unused word lane carries the same lane of the flit sent before it, so that wire does not toggle. For a writeback, the caller marks clean words as unused in the vector. Routing, credit flow control and the cache-side protocol are handled elsewhere.

The controller has three states. `ST_IDLE` waits for a start pulse and captures the block. `ST_HEAD` emits the head flit. `ST_DATA` emits one kept data flit per cycle. The transitions are:
- IDLE to HEAD when `start` is sampled high.
- HEAD to DATA when any word is used.
- HEAD to IDLE when the vector is all zero.
- DATA to DATA while a later kept flit remains.
- DATA to IDLE after the last kept flit.

A four-lane holding register records the last flit that went onto the wire. That record survives across packets, and dropped flits never update it.

Top module: `spl_packet_composer`

## Requirements
- R1: After reset, `idle` is 1 and `flit_valid` is 0. The holding register starts at all zeros.
- R2: A `start` sampled high while idle is accepted. The head flit is presented in the following cycle. Flit layout: bit 130 is the virtual-channel bit, bits 129:128 are the flit type, and bits 127:0 are four 32-bit lanes, lane m at bits 32m+31:32m. In the head, lane 0 is the block address and lane 1 is {used-vector[15:0], source[7:0], destination[7:0]}.
- R3: Data flit j carries block words 4j to 4j+3, word 4j+m in lane m. Word i of `blk_data` is bits 32i+31:32i, and bit i of the used-vector marks word i. A used word appears unchanged.
- R4: A data flit whose four used-vector bits are all zero is not sent. The kept data flits follow the head on consecutive cycles, in increasing flit index.
- R5: An unused lane of a data flit carries the value that lane had in the last transmitted flit, which may be a head flit or a flit of an earlier packet. Dropped flits do not change that value.
- R6: Head lanes 2 and 3 repeat the same lanes of the last transmitted flit.
- R7: Flit types are 00 head, 01 body, 10 tail and 11 atomic. The last kept data flit is a tail, and the other kept data flits are bodies.
- R8: An all-zero used-vector produces a single flit of type atomic, with no data flits.
- R9: A `start` that arrives while a packet is in progress is ignored. The packet in flight and the cycles after it are unchanged.
- R10: `idle` returns to 1 in the cycle after the last flit of a packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Capture the block inputs when idle |
| blk_data | input | 512 | Sixteen 32-bit block words |
| used_vec | input | 16 | Per-word used marks, bit i for word i |
| src_node | input | 8 | Source node id |
| dst_node | input | 8 | Destination node id |
| blk_addr | input | 32 | Block address |
| vc_in | input | 1 | Virtual-channel id |
| idle | output | 1 | Ready to accept a new block |
| flit_valid | output | 1 | A flit is on `flit_out` this cycle |
| flit_out | output | 131 | {vc, type, lane3..lane0} |

## Verification
The bench builds the block with its defaults: 32-bit words, four lanes, four data flits, 8-bit node ids and a 32-bit address. With these values, every drop pattern of a full block can be reached. This makes it possible to run:
- a full block;
- a packet with a gap in the middle;
- a packet whose only data flit is the last one;
- an all-zero vector that yields an atomic flit.

Because the holding register persists between packets, a reference model in the bench carries the lane history from one scenario to the next. That shows repetition across packet boundaries and through the head.

// File: rtl/spl_pkg.sv
package spl_pkg;

    typedef enum logic [1:0] {
        FT_HEAD = 2'b00,
        FT_BODY = 2'b01,
        FT_TAIL = 2'b10,
        FT_ATOM = 2'b11
    } flit_type_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HEAD = 2'd1,
        ST_DATA = 2'd2
    } comp_state_e;

endpackage

// File: rtl/spl_keep_scan.sv
module spl_keep_scan #(
    parameter int LANES      = 4,
    parameter int DATA_FLITS = 4,
    parameter int IDX_W      = (DATA_FLITS > 1) ? $clog2(DATA_FLITS) : 1
) (
    input  logic [LANES*DATA_FLITS-1:0] used,
    input  logic [IDX_W-1:0]            cur_idx,
    output logic                        any_keep,
    output logic [IDX_W-1:0]            first_idx,
    output logic                        has_next,
    output logic [IDX_W-1:0]            next_idx
);

    logic [DATA_FLITS-1:0] keep;

    // A data flit is kept when any of its lanes is marked used.
    for (genvar j = 0; j < DATA_FLITS; j++) begin : g_keep
        assign keep[j] = |used[j*LANES +: LANES];
    end

    assign any_keep = |keep;

    // Lowest kept index overall, and lowest kept index above cur_idx.
    always_comb begin
        first_idx = '0;
        has_next  = 1'b0;
        next_idx  = '0;
        for (int j = DATA_FLITS - 1; j >= 0; j--) begin
            if (keep[j]) begin
                first_idx = IDX_W'(j);
            end
            if (keep[j] && (j > int'(cur_idx))) begin
                has_next = 1'b1;
                next_idx = IDX_W'(j);
            end
        end
    end

endmodule

// File: rtl/spl_lane_repeat.sv
module spl_lane_repeat #(
    parameter int WORD_W = 32,
    parameter int LANES  = 4,
    localparam int DW    = WORD_W * LANES
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [LANES-1:0] sel_fresh,
    input  logic [DW-1:0]    fresh,
    output logic [DW-1:0]    lanes_out
);

    logic [DW-1:0] hold_q;

    // Each lane either passes its fresh word or repeats the held one.
    for (genvar m = 0; m < LANES; m++) begin : g_lane
        assign lanes_out[m*WORD_W +: WORD_W] =
            sel_fresh[m] ? fresh[m*WORD_W +: WORD_W] : hold_q[m*WORD_W +: WORD_W];
    end

    // Remember what actually went onto the wire.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= '0;
        end else if (load) begin
            hold_q <= lanes_out;
        end
    end

endmodule

// File: rtl/spl_packet_composer.sv
module spl_packet_composer
    import spl_pkg::*;
#(
    parameter int WORD_W     = 32,
    parameter int LANES      = 4,
    parameter int DATA_FLITS = 4,
    parameter int NODE_W     = 8,
    parameter int ADDR_W     = 32,
    localparam int NUM_WORDS  = LANES * DATA_FLITS,
    localparam int FLIT_DW    = LANES * WORD_W,
    localparam int FLIT_W     = FLIT_DW + 3,
    localparam int BLK_W      = NUM_WORDS * WORD_W,
    localparam int IDX_W      = (DATA_FLITS > 1) ? $clog2(DATA_FLITS) : 1,
    localparam int HEAD_BITS  = NUM_WORDS + 2 * NODE_W + ADDR_W,
    localparam int HEAD_LANES = (HEAD_BITS + WORD_W - 1) / WORD_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [BLK_W-1:0]     blk_data,
    input  logic [NUM_WORDS-1:0] used_vec,
    input  logic [NODE_W-1:0]    src_node,
    input  logic [NODE_W-1:0]    dst_node,
    input  logic [ADDR_W-1:0]    blk_addr,
    input  logic                 vc_in,
    output logic                 idle,
    output logic                 flit_valid,
    output logic [FLIT_W-1:0]    flit_out
);

    comp_state_e            st_q;
    logic [IDX_W-1:0]       idx_q;
    logic [BLK_W-1:0]       blk_q;
    logic [NUM_WORDS-1:0]   used_q;
    logic [NODE_W-1:0]      src_q;
    logic [NODE_W-1:0]      dst_q;
    logic [ADDR_W-1:0]      addr_q;
    logic                   vc_q;

    logic                   any_keep;
    logic [IDX_W-1:0]       first_idx;
    logic                   has_next;
    logic [IDX_W-1:0]       next_idx;

    logic [LANES-1:0]       sel_fresh;
    logic [FLIT_DW-1:0]     fresh;
    logic [FLIT_DW-1:0]     lanes;
    flit_type_e             ftype;
    logic [FLIT_DW-1:0]     head_word;
    logic [LANES-1:0]       head_sel;

    spl_keep_scan #(
        .LANES      (LANES),
        .DATA_FLITS (DATA_FLITS),
        .IDX_W      (IDX_W)
    ) u_scan (
        .used      (used_q),
        .cur_idx   (idx_q),
        .any_keep  (any_keep),
        .first_idx (first_idx),
        .has_next  (has_next),
        .next_idx  (next_idx)
    );

    spl_lane_repeat #(
        .WORD_W (WORD_W),
        .LANES  (LANES)
    ) u_lanes (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (flit_valid),
        .sel_fresh (sel_fresh),
        .fresh     (fresh),
        .lanes_out (lanes)
    );

    // Head payload packed from bit 0; lanes past it repeat.
    always_comb begin
        head_word = '0;
        head_word[HEAD_BITS-1:0] = {used_q, src_q, dst_q, addr_q};
        head_sel = '0;
        for (int m = 0; m < LANES; m++) begin
            if (m < HEAD_LANES) begin
                head_sel[m] = 1'b1;
            end
        end
    end

    // Block capture: only when idle, so starts during a packet are dropped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            blk_q  <= '0;
            used_q <= '0;
            src_q  <= '0;
            dst_q  <= '0;
            addr_q <= '0;
            vc_q   <= 1'b0;
        end else if (st_q == ST_IDLE && start) begin
            blk_q  <= blk_data;
            used_q <= used_vec;
            src_q  <= src_node;
            dst_q  <= dst_node;
            addr_q <= blk_addr;
            vc_q   <= vc_in;
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            idx_q <= '0;
        end else begin
            unique case (st_q)
                ST_IDLE: begin
                    if (start) begin
                        st_q <= ST_HEAD;
                    end
                end
                ST_HEAD: begin
                    if (any_keep) begin
                        st_q  <= ST_DATA;
                        idx_q <= first_idx;
                    end else begin
                        st_q <= ST_IDLE;
                    end
                end
                ST_DATA: begin
                    if (has_next) begin
                        idx_q <= next_idx;
                    end else begin
                        st_q <= ST_IDLE;
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    // Outputs.
    always_comb begin
        sel_fresh  = '0;
        fresh      = '0;
        ftype      = FT_HEAD;
        flit_valid = 1'b0;
        idle       = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                idle = 1'b1;
            end
            ST_HEAD: begin
                flit_valid = 1'b1;
                fresh      = head_word;
                sel_fresh  = head_sel;
                ftype      = any_keep ? FT_HEAD : FT_ATOM;
            end
            ST_DATA: begin
                flit_valid = 1'b1;
                fresh      = blk_q[int'(idx_q) * FLIT_DW +: FLIT_DW];
                sel_fresh  = used_q[int'(idx_q) * LANES +: LANES];
                ftype      = has_next ? FT_BODY : FT_TAIL;
            end
            default: begin
                idle = 1'b0;
            end
        endcase
    end

    assign flit_out = {vc_q, ftype, lanes};

    // R2: a packet always opens with a head or an atomic flit.
    a_r2_opens_with_head: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flit_valid) |->
            (flit_out[FLIT_DW+1:FLIT_DW] == FT_HEAD || flit_out[FLIT_DW+1:FLIT_DW] == FT_ATOM));

    // R7 and R10: a tail ends the packet, and idle follows.
    a_r7_tail_closes: assert property (@(posedge clk) disable iff (!rst_n)
        (flit_valid && flit_out[FLIT_DW+1:FLIT_DW] == FT_TAIL) |=> (!flit_valid && idle));

    // R8: an atomic flit stands alone.
    a_r8_atomic_alone: assert property (@(posedge clk) disable iff (!rst_n)
        (flit_valid && flit_out[FLIT_DW+1:FLIT_DW] == FT_ATOM) |=> !flit_valid);

    // R4: a body flit is always followed by another data flit.
    a_r4_no_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (flit_valid && flit_out[FLIT_DW+1:FLIT_DW] == FT_BODY) |=>
            (flit_valid && (flit_out[FLIT_DW+1:FLIT_DW] == FT_BODY ||
                            flit_out[FLIT_DW+1:FLIT_DW] == FT_TAIL)));

    // R5 and R6: a lane not refreshed keeps its value from the previous sent flit.
    for (genvar m = 0; m < LANES; m++) begin : g_chk
        a_r5_lane_repeat: assert property (@(posedge clk) disable iff (!rst_n)
            (flit_valid && !sel_fresh[m] && $past(flit_valid)) |->
                (flit_out[m*WORD_W +: WORD_W] == $past(flit_out[m*WORD_W +: WORD_W])));
    end

endmodule

// File: tb/sim_spl_packet_composer.sv
module sim_spl_packet_composer;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [511:0] blk_data = '0;
    logic [15:0]  used_vec = '0;
    logic [7:0]   src_node = '0;
    logic [7:0]   dst_node = '0;
    logic [31:0]  blk_addr = '0;
    logic         vc_in = 1'b0;
    logic         idle;
    logic         flit_valid;
    logic [130:0] flit_out;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    // Reference copy of the lanes last put on the wire.
    logic [31:0] mh [4];

    always #5 clk = ~clk;

    spl_packet_composer u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .blk_data   (blk_data),
        .used_vec   (used_vec),
        .src_node   (src_node),
        .dst_node   (dst_node),
        .blk_addr   (blk_addr),
        .vc_in      (vc_in),
        .idle       (idle),
        .flit_valid (flit_valid),
        .flit_out   (flit_out)
    );

    task automatic check(input string req, input logic [130:0] act, input logic [130:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] word_of(input logic [31:0] seed, input int i);
        return seed + 32'(i) * 32'h0101_0107;
    endfunction

    // Send one block and compare every flit against the reference model.
    task automatic send_block(input string req, input logic [15:0] vec, input logic [31:0] seed,
                              input logic vc, input bit poke);
        logic [130:0] exp [5];
        int           n_exp = 0;
        int           last_data = -1;
        logic [511:0] blk;
        logic [31:0]  addr;
        for (int i = 0; i < 16; i++) blk[i*32 +: 32] = word_of(seed, i);
        addr = seed ^ 32'hA5A5_0040;
        // Head: lane0 address, lane1 {vec, src, dst}, lanes 2 and 3 repeat.
        exp[0] = {vc, (vec == 16'h0) ? 2'b11 : 2'b00, mh[3], mh[2],
                  {vec, seed[7:0], seed[15:8]}, addr};
        mh[0] = addr;
        mh[1] = {vec, seed[7:0], seed[15:8]};
        n_exp = 1;
        for (int j = 0; j < 4; j++) begin
            if (vec[j*4 +: 4] != 4'h0) begin
                logic [127:0] d;
                for (int m = 0; m < 4; m++) begin
                    if (vec[j*4+m]) mh[m] = word_of(seed, j*4+m);
                    d[m*32 +: 32] = mh[m];
                end
                exp[n_exp] = {vc, 2'b01, d};
                last_data = n_exp;
                n_exp++;
            end
        end
        if (last_data > 0) exp[last_data][129:128] = 2'b10;

        @(negedge clk);
        blk_data = blk;
        used_vec = vec;
        src_node = seed[7:0];
        dst_node = seed[15:8];
        blk_addr = addr;
        vc_in    = vc;
        start    = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        for (int k = 0; k < n_exp; k++) begin
            check({req, " valid"}, {130'h0, flit_valid}, 131'h1);
            check(req, flit_out, exp[k]);
            if (poke && k == 1) begin
                start    = 1'b1;
                used_vec = ~vec;
                blk_data = ~blk;
                vc_in    = ~vc;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
        end
        start = 1'b0;
        check({req, " R10 idle after packet"}, {129'h0, idle, flit_valid}, 131'h2);
        @(negedge clk);
        check({req, " R9 no stray packet"}, {129'h0, idle, flit_valid}, 131'h2);
    endtask

    task automatic t_reset();
        check("R1 reset idle/valid", {129'h0, idle, flit_valid}, 131'h2);
    endtask

    task automatic t_full();
        send_block("R3/R7 full block", 16'hFFFF, 32'h1000_2233, 1'b0, 1'b0);
    endtask

    task automatic t_gap();
        // Words 0-5, 12 and 14 used: flit 2 dropped, lanes repeat.
        send_block("R4/R5 middle drop", 16'h503F, 32'h7711_4C01, 1'b1, 1'b0);
    endtask

    task automatic t_last_only();
        send_block("R4/R6 last flit only", 16'h8000, 32'h0F0E_5502, 1'b0, 1'b0);
    endtask

    task automatic t_atomic();
        send_block("R8 all-zero atomic", 16'h0000, 32'h3C3C_9903, 1'b1, 1'b0);
    endtask

    task automatic t_busy();
        send_block("R9 start while busy", 16'hF0F1, 32'h2468_1304, 1'b0, 1'b1);
    endtask

    task automatic t_sparse();
        send_block("R2/R5 sparse lanes", 16'h2481, 32'hDEAD_6605, 1'b1, 1'b0);
    endtask

    initial begin
        for (int m = 0; m < 4; m++) mh[m] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_full();
        t_gap();
        t_last_only();
        t_atomic();
        t_busy();
        t_sparse();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule